// File: doc/BRIEF.md
# Short-Address DMA Channel

This block is one DMA channel that moves a single byte or a single word each time its selected activation event fires. One side of every transfer is a 24-bit memory address. The other side is an 8-bit short address that points into the top I/O page of the address space. The channel has no direction bit. It works out which way the data goes from the event that starts it: a serial receive-data-full event reads the I/O side and writes memory, and every other source reads memory and writes the I/O side.

Software sets up the channel through a small register-write port. It loads a memory address, a short I/O address, a 16-bit transfer count and a control word that picks the mode, the transfer size, the stepping direction, interrupt enable and the activation source. Each transfer runs as two single-beat accesses on a simple bus master port: a read, then a write.

The channel has three modes:
- **I/O mode** steps the memory address after each transfer and stops when the count runs out.
- **Idle mode** keeps both addresses fixed.
- **Repeat mode** restores the starting memory address and count at the end and keeps running.

The end of a count in I/O or idle mode can raise an interrupt.

Top module: `sadma_channel`

## Requirements
- R1: Each accepted request performs exactly one transfer: one read beat (`bus_we`=0) followed directly by one write beat (`bus_we`=1). `bus_word` is 1 for a word and 0 for a byte. A byte transfer writes the low 8 bits of the read data with the upper bits zero.
- R2: With source code 5 (receive-data-full) the read beat goes to the I/O address and the write beat goes to the memory address. With any other source the read beat goes to the memory address and the write beat goes to the I/O address.
- R3: The I/O-side bus address is the 8-bit short address with its upper 16 bits all ones (0xFFFFxx).
- R4: In I/O mode (mode code 0) and repeat mode (code 2), the memory address moves by 1 for byte transfers and by 2 for word transfers after each transfer. It increments when the decrement bit is 0 and decrements when it is 1.
- R5: In idle mode (mode code 1), neither the memory address nor the I/O address changes between transfers.
- R6: Each transfer lowers the count by one. When the count reaches zero in I/O or idle mode, the channel disables itself and later requests cause no bus activity.
- R7: When the count runs out in I/O or idle mode and interrupt enable is set, `irq` goes high and stays high until the next control-register write. It is low before the last transfer completes.
- R8: In repeat mode, when the count runs out the starting memory address and count are restored, the channel stays enabled, and `irq` is never raised.
- R9: A request that arrives while a transfer is in progress is held. It is serviced as one further transfer after the current one finishes.
- R10: While the enable bit is 0, requests cause no bus activity.
- R11: Strobes from sources other than the selected one are ignored. Source code 6 (external request) is accepted only when the channel is built as a B channel (`IS_B_CH`=1).
- R12: After reset `bus_req` and `irq` are low.

Control word (`cfg_sel`=3), by bit:
- [0] enable
- [2:1] mode
- [3] word
- [4] decrement
- [5] interrupt enable
- [8:6] source: 0–3 timer channel, 4 transmit-data-empty, 5 receive-data-full, 6 external

Other `cfg_sel` codes:
- 0: memory address
- 1: short I/O address
- 2: transfer count

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 24 | Register write data |
| tmr_req | input | 4 | Timer compare/capture event strobes |
| sci_txe | input | 1 | Serial transmit-data-empty strobe |
| sci_rxf | input | 1 | Serial receive-data-full strobe |
| ext_req | input | 1 | External request strobe |
| bus_req | output | 1 | Bus beat valid |
| bus_we | output | 1 | Beat is a write |
| bus_word | output | 1 | Beat is a word access |
| bus_addr | output | 24 | Beat address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ack | input | 1 | Beat accepted |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The bench fires two strobes on consecutive cycles to check the pending request. A design that dropped the pending request would make one write instead of two. It runs a repeat-mode count past its end: a channel that failed to reload would read a stepped address on the third transfer, and one that stopped or raised `irq` would show it at the ports. It sends a request after the count has run out in I/O mode and expects no write, which catches an off-by-one count or a channel that fails to disable itself. It also uses receive-data-full sources, a source that is not selected, and an A-channel instance given an external request. These catch a design that reverses the direction or takes events it should ignore.

// File: rtl/sadma_pkg.sv
package sadma_pkg;

  typedef enum logic [1:0] {
    MODE_IO   = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_RPT  = 2'd2,
    MODE_RSV  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    SRC_TMR0 = 3'd0,
    SRC_TMR1 = 3'd1,
    SRC_TMR2 = 3'd2,
    SRC_TMR3 = 3'd3,
    SRC_TXE  = 3'd4,
    SRC_RXF  = 3'd5,
    SRC_EXT  = 3'd6,
    SRC_NONE = 3'd7
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } st_e;

  typedef struct packed {
    src_e  src;
    logic  irq_en;
    logic  dec;
    logic  word;
    mode_e mode;
    logic  en;
  } ctl_t;

  localparam logic [1:0] SEL_MEM = 2'd0;
  localparam logic [1:0] SEL_IO  = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

endpackage

// File: rtl/sadma_req_sel.sv
module sadma_req_sel
  import sadma_pkg::*;
#(
  parameter int TMR_N   = 4,
  parameter bit IS_B_CH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             src,
  input  logic [TMR_N-1:0] tmr_req,
  input  logic             sci_txe,
  input  logic             sci_rxf,
  input  logic             ext_req,
  output logic             hit,
  output logic             to_mem
);

  logic ext_ok;

  generate
    if (IS_B_CH) begin : g_b_ch
      assign ext_ok = ext_req;
    end else begin : g_a_ch
      assign ext_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < TMR_N; i++) begin
      if (int'(src) == i) hit = tmr_req[i];
    end
    case (src)
      SRC_TXE: hit = sci_txe;
      SRC_RXF: hit = sci_rxf;
      SRC_EXT: hit = ext_ok;
      default: ;
    endcase
  end

  assign to_mem = (src == SRC_RXF);

  // R11
  a_ch_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_B_CH && src == SRC_EXT) |-> !hit);

endmodule

// File: rtl/sadma_addr_unit.sv
module sadma_addr_unit
  import sadma_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [MEM_AW-1:0] wr_data,
  input  logic              step,
  input  mode_e             mode,
  input  logic              word,
  input  logic              dec,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_AW-1:0] io_addr,
  output logic              last
);

  localparam int PAGE_W = MEM_AW - IO_AW;

  logic [MEM_AW-1:0] mem_init_q, mem_init_d, mem_cur_q, mem_cur_d;
  logic [CNT_W-1:0]  cnt_init_q, cnt_init_d, cnt_cur_q, cnt_cur_d;
  logic [IO_AW-1:0]  io_q, io_d;
  logic [MEM_AW-1:0] stride;
  logic              upd_en;

  assign stride   = word ? MEM_AW'(2) : MEM_AW'(1);
  assign last     = (cnt_cur_q == CNT_W'(1));
  assign mem_addr = mem_cur_q;
  assign io_addr  = {{PAGE_W{1'b1}}, io_q};
  assign upd_en   = wr_en | step;

  always_comb begin
    mem_init_d = mem_init_q;
    mem_cur_d  = mem_cur_q;
    cnt_init_d = cnt_init_q;
    cnt_cur_d  = cnt_cur_q;
    io_d       = io_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_MEM: begin
          mem_init_d = wr_data;
          mem_cur_d  = wr_data;
        end
        SEL_IO:  io_d = wr_data[IO_AW-1:0];
        SEL_CNT: begin
          cnt_init_d = wr_data[CNT_W-1:0];
          cnt_cur_d  = wr_data[CNT_W-1:0];
        end
        default: ;
      endcase
    end else if (step) begin
      if (mode == MODE_RPT && last) begin
        mem_cur_d = mem_init_q;
        cnt_cur_d = cnt_init_q;
      end else begin
        cnt_cur_d = cnt_cur_q - CNT_W'(1);
        if (mode != MODE_IDLE) begin
          mem_cur_d = dec ? (mem_cur_q - stride) : (mem_cur_q + stride);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_init_q <= '0;
      mem_cur_q  <= '0;
      cnt_init_q <= '0;
      cnt_cur_q  <= '0;
      io_q       <= '0;
    end else if (upd_en) begin
      mem_init_q <= mem_init_d;
      mem_cur_q  <= mem_cur_d;
      cnt_init_q <= cnt_init_d;
      cnt_cur_q  <= cnt_cur_d;
      io_q       <= io_d;
    end
  end

  // R5
  idle_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && mode == MODE_IDLE) |=> ($stable(mem_addr) && $stable(io_addr)));

  // R8
  rpt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && mode == MODE_RPT && last) |=> (mem_addr == mem_init_q));

endmodule

// File: rtl/sadma_ctrl.sv
module sadma_ctrl
  import sadma_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  ctl_t              ctl_wdata,
  input  logic              req_hit,
  input  logic              to_mem,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [MEM_AW-1:0] io_addr,
  input  logic              last,
  input  logic              bus_ack,
  input  logic [DW-1:0]     bus_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              step,
  output ctl_t              ctl,
  output logic              irq
);

  st_e           st_q, st_d;
  ctl_t          ctl_q, ctl_d;
  logic          pend_q, pend_d;
  logic          done_q, done_d;
  logic [DW-1:0] dbuf_q, dbuf_d;

  assign ctl = ctl_q;

  always_comb begin
    st_d   = st_q;
    ctl_d  = ctl_q;
    pend_d = pend_q;
    done_d = done_q;
    dbuf_d = dbuf_q;
    step   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ctl_q.en && (req_hit || pend_q)) begin
          st_d   = ST_RD;
          pend_d = 1'b0;
        end
      end
      ST_RD: begin
        if (req_hit && ctl_q.en) pend_d = 1'b1;
        if (bus_ack) begin
          dbuf_d = bus_rdata;
          st_d   = ST_WR;
        end
      end
      ST_WR: begin
        if (req_hit && ctl_q.en) pend_d = 1'b1;
        if (bus_ack) begin
          step = 1'b1;
          st_d = ST_IDLE;
          if (last && ctl_q.mode != MODE_RPT) begin
            ctl_d.en = 1'b0;
            pend_d   = 1'b0;
            done_d   = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (ctl_we) begin
      ctl_d  = ctl_wdata;
      done_d = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ctl_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      dbuf_q <= '0;
    end else begin
      st_q   <= st_d;
      ctl_q  <= ctl_d;
      pend_q <= pend_d;
      done_q <= done_d;
      dbuf_q <= dbuf_d;
    end
  end

  assign bus_req   = (st_q != ST_IDLE);
  assign bus_we    = (st_q == ST_WR);
  assign bus_word  = ctl_q.word;
  assign bus_addr  = (bus_we ^ to_mem) ? io_addr : mem_addr;
  assign bus_wdata = ctl_q.word ? dbuf_q : DW'(dbuf_q[7:0]);
  assign irq       = done_q & ctl_q.irq_en;

  // R1
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> $past(bus_req && !bus_we && bus_ack));

  // R3
  io_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (bus_we != to_mem)) |-> (&bus_addr[MEM_AW-1:8]));

  // R6
  done_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !ctl_q.en);

  // R8
  rpt_stays_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ctl_q.mode == MODE_RPT && !ctl_we) |=> (ctl_q.en && !irq));

  // R10
  off_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !ctl_q.en) |=> !bus_req);

endmodule

// File: rtl/sadma_channel.sv
module sadma_channel
  import sadma_pkg::*;
#(
  parameter int MEM_AW  = 24,
  parameter int IO_AW   = 8,
  parameter int CNT_W   = 16,
  parameter int DW      = 16,
  parameter int TMR_N   = 4,
  parameter bit IS_B_CH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [MEM_AW-1:0] cfg_wdata,
  input  logic [TMR_N-1:0]  tmr_req,
  input  logic              sci_txe,
  input  logic              sci_rxf,
  input  logic              ext_req,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ack,
  output logic              irq
);

  localparam int CTL_W = $bits(ctl_t);

  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  logic              hit, to_mem, last, step, ctl_we;
  logic [MEM_AW-1:0] mem_addr, io_addr;
  ctl_t              ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];
  assign ctl_we = cfg_we && (cfg_sel == SEL_CTL);

  sadma_req_sel #(.TMR_N(TMR_N), .IS_B_CH(IS_B_CH)) u_req_sel (
    .clk(clk), .rst_n(rst_ns), .src(ctl.src), .tmr_req(tmr_req),
    .sci_txe(sci_txe), .sci_rxf(sci_rxf), .ext_req(ext_req),
    .hit(hit), .to_mem(to_mem)
  );

  sadma_addr_unit #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_ns), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .step(step), .mode(ctl.mode), .word(ctl.word),
    .dec(ctl.dec), .mem_addr(mem_addr), .io_addr(io_addr), .last(last)
  );

  sadma_ctrl #(.MEM_AW(MEM_AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_ns), .ctl_we(ctl_we),
    .ctl_wdata(ctl_t'(cfg_wdata[CTL_W-1:0])), .req_hit(hit), .to_mem(to_mem),
    .mem_addr(mem_addr), .io_addr(io_addr), .last(last), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .step(step), .ctl(ctl), .irq(irq)
  );

endmodule

// File: tb/sadma_channel_tb.sv
module sadma_channel_tb;

  typedef struct packed {
    logic [8:0]  ctl;
    logic [23:0] mem;
    logic [7:0]  io;
    logic [23:0] waddr;
    logic [15:0] wdata;
  } vec_t;

  // ctl = {src[2:0], irq_en, dec, word, mode[1:0], en}
  localparam vec_t VECS [6] = '{
    '{ {3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1}, 24'h001234, 8'h40, 24'hFFFF40, 16'h00F7 },
    '{ {3'd4, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1}, 24'h002000, 8'h80, 24'hFFFF80, 16'h85C3 },
    '{ {3'd5, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1}, 24'h003000, 8'h10, 24'h003000, 16'h5AD3 },
    '{ {3'd5, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1}, 24'h004001, 8'hF2, 24'h004001, 16'h0031 },
    '{ {3'd6, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1}, 24'h00ABCE, 8'h33, 24'hFFFF33, 16'h0E0D },
    '{ {3'd3, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1}, 24'h000010, 8'h01, 24'hFFFF01, 16'h00D3 }
  };

  logic        clk, rst_n;
  logic        cfg_we, cfg_we_a;
  logic [1:0]  cfg_sel;
  logic [23:0] cfg_wdata;
  logic [3:0]  tmr_req;
  logic        sci_txe, sci_rxf, ext_req;
  logic        bus_req, bus_we, bus_word, bus_ack, irq;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        a_req, a_we, a_word, a_irq;
  logic [23:0] a_addr;
  logic [15:0] a_wdata;

  int n_chk, n_fail, wr_cnt, rd_cnt, a_req_cnt;
  logic [23:0] last_raddr, last_waddr;
  logic [15:0] last_wdata;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign bus_ack   = bus_req;
  assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;

  sadma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tmr_req(tmr_req), .sci_txe(sci_txe),
    .sci_rxf(sci_rxf), .ext_req(ext_req), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
  );

  sadma_channel #(.IS_B_CH(1'b0)) u_dut_a (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_a), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tmr_req(tmr_req), .sci_txe(sci_txe),
    .sci_rxf(sci_rxf), .ext_req(ext_req), .bus_req(a_req), .bus_we(a_we),
    .bus_word(a_word), .bus_addr(a_addr), .bus_wdata(a_wdata),
    .bus_rdata(16'h0000), .bus_ack(a_req), .irq(a_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= 0; rd_cnt <= 0; a_req_cnt <= 0;
      last_raddr <= '0; last_waddr <= '0; last_wdata <= '0;
    end else begin
      if (bus_req && !bus_we) begin
        rd_cnt <= rd_cnt + 1; last_raddr <= bus_addr;
      end
      if (bus_req && bus_we) begin
        wr_cnt <= wr_cnt + 1; last_waddr <= bus_addr; last_wdata <= bus_wdata;
      end
      if (a_req) a_req_cnt <= a_req_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [23:0] d, input bit to_a);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d;
    if (to_a) cfg_we_a = 1'b1; else cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_we_a = 1'b0;
  endtask

  task automatic setup(input logic [8:0] ctl, input logic [23:0] mem,
                       input logic [7:0] io, input logic [15:0] cnt);
    wr_reg(2'd0, mem, 1'b0);
    wr_reg(2'd1, {16'h0, io}, 1'b0);
    wr_reg(2'd2, {8'h0, cnt}, 1'b0);
    wr_reg(2'd3, {15'h0, ctl}, 1'b0);
  endtask

  task automatic drive_src(input int src, input logic v);
    case (src)
      0, 1, 2, 3: tmr_req[src] = v;
      4: sci_txe = v;
      5: sci_rxf = v;
      default: ext_req = v;
    endcase
  endtask

  task automatic pulse(input int src, input int len);
    @(negedge clk);
    drive_src(src, 1'b1);
    repeat (len) @(negedge clk);
    drive_src(src, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w0;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_we_a = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    tmr_req = '0; sci_txe = 1'b0; sci_rxf = 1'b0; ext_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 bus_req", {31'h0, bus_req}, 32'h0);
    chk("R12 irq", {31'h0, irq}, 32'h0);

    // R1 R2 R3: table of single transfers
    for (int i = 0; i < 6; i++) begin
      setup(VECS[i].ctl, VECS[i].mem, VECS[i].io, 16'd5);
      w0 = wr_cnt;
      pulse(int'(VECS[i].ctl[8:6]), 1);
      chk("R1 one write", wr_cnt - w0, 1);
      chk("R2/R3 write addr", {8'h0, last_waddr}, {8'h0, VECS[i].waddr});
      chk("R1 write data", {16'h0, last_wdata}, {16'h0, VECS[i].wdata});
    end

    // R4 word increment, then byte decrement
    setup({3'd4, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1}, 24'h000100, 8'h50, 16'd5);
    pulse(4, 1); pulse(4, 1);
    chk("R4 word inc", {8'h0, last_raddr}, 32'h000102);
    setup({3'd4, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1}, 24'h000100, 8'h50, 16'd5);
    pulse(4, 1); pulse(4, 1);
    chk("R4 byte dec", {8'h0, last_raddr}, 32'h0000FF);

    // R5 idle mode holds both addresses
    setup({3'd4, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1}, 24'h000500, 8'h44, 16'd5);
    pulse(4, 1); pulse(4, 1); pulse(4, 1);
    chk("R5 mem fixed", {8'h0, last_raddr}, 32'h000500);
    chk("R5 io fixed", {8'h0, last_waddr}, 32'hFFFF44);

    // R6 R7 count end in I/O mode with interrupt
    setup({3'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1}, 24'h000600, 8'h20, 16'd2);
    pulse(1, 1);
    chk("R7 irq before end", {31'h0, irq}, 32'h0);
    pulse(1, 1);
    chk("R7 irq at end", {31'h0, irq}, 32'h1);
    w0 = wr_cnt;
    pulse(1, 1);
    chk("R6 stopped after count", wr_cnt - w0, 0);
    wr_reg(2'd3, {15'h0, 3'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0}, 1'b0);
    @(negedge clk);
    chk("R7 irq cleared", {31'h0, irq}, 32'h0);

    // R8 repeat reload, no interrupt, stays enabled
    setup({3'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1}, 24'h000200, 8'h21, 16'd2);
    pulse(2, 1); pulse(2, 1); pulse(2, 1);
    chk("R8 reload addr", {8'h0, last_raddr}, 32'h000200);
    chk("R8 no irq", {31'h0, irq}, 32'h0);
    w0 = wr_cnt;
    pulse(2, 1);
    chk("R8 still active", wr_cnt - w0, 1);
    chk("R8 step after reload", {8'h0, last_raddr}, 32'h000201);

    // R9 request during transfer is held
    setup({3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1}, 24'h000300, 8'h22, 16'd5);
    w0 = wr_cnt;
    pulse(0, 2);
    chk("R9 pending served", wr_cnt - w0, 2);
    chk("R9 second addr", {8'h0, last_raddr}, 32'h000301);

    // R10 disabled channel ignores requests
    setup({3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, 24'h000700, 8'h23, 16'd5);
    w0 = wr_cnt;
    pulse(0, 1);
    chk("R10 disabled", wr_cnt - w0, 0);

    // R11 unselected source, and external on an A channel
    setup({3'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1}, 24'h000700, 8'h23, 16'd5);
    w0 = wr_cnt;
    pulse(5, 1);
    chk("R11 unselected", wr_cnt - w0, 0);
    wr_reg(2'd2, 24'd5, 1'b1);
    wr_reg(2'd3, {15'h0, 3'd6, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1}, 1'b1);
    pulse(6, 1);
    chk("R11 A channel external", a_req_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule